// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block is the command front end of a small boot-block NOR flash. Every cycle in which the bus-write strobe is high, it takes the address and data of that write and steps a sequence recogniser. The recogniser follows the two-write unlock prefix and the command byte that comes after it. When a sequence completes, the block issues a one-cycle command pulse to the program/erase controller. The pulse carries the address and data of the write that completed the sequence. The block also keeps track of the mode the device is in: plain read, identifier read, shortened-program (bypass) mode, controller busy, or erase suspended.

A host-selected byte-wide bus mode shifts the two key addresses. Only the low address bits and the low data byte take part in matching. The controller reports whether an operation is running through a busy input. That input decides which writes are still honoured: none while a program or chip erase runs, and only suspend or reset while a block erase runs. The memory array, the operation timing and block protection live elsewhere.

Top module: `nor_cmd_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, with no write, `mode_o` is 0 (read) and `cmd_valid_o` is 0.
- R2: Word mode (`byte_mode`=0) compares address bits 10:0 against command key 555h and unlock key 2AAh. Byte mode (`byte_mode`=1) compares bits 11:0 against AAAh (command) and 555h (unlock). Higher address bits and data bits 15:8 never affect decoding.
- R3: The unlock prefix is AAh written at the command key, then 55h at the unlock key. A third write at the command key then selects the command. 90h pulses identifier select (code 2) and sets mode 1, which persists until the next write. 20h pulses bypass entry (code 4) and sets mode 2. A0h arms program: the next write, at any address and with any data, pulses program (code 3) with that write's address and data, and mode returns to 0.
- R4: The erase sequence is prefix, 80h at the command key, prefix again, then a final write. 10h at the command key pulses chip erase (code 7). 30h at any address pulses block erase (code 8) with that address.
- R5: Outside bypass mode and outside the program data write, F0h at any address and at any sequence step pulses reset (code 1) and sets the base mode to read.
- R6: A write that does not continue a valid sequence produces no pulse and returns mode 1 to read (0).
- R7: In bypass mode, A0h followed by any write pulses bypass program (code 5) and bypass mode remains. 90h followed by 00h pulses bypass reset (code 6) and sets mode 0. Every other write, F0h included, produces no pulse and leaves mode 2.
- R8: While `ctl_busy` is high after a program, bypass program or chip erase, every write is ignored and `mode_o` reads 3 (busy).
- R9: While `ctl_busy` is high after a block erase or resume, B0h pulses suspend (code 9) and F0h pulses reset. Other writes are ignored. Once busy drops after a suspend, `mode_o` reads 4.
- R10: While suspended, a single 30h write pulses resume (code 10) and clears the suspension. Prefix+A0h programs as usual, and prefix+90h selects identifier mode (1). A following reset returns to mode 4. Prefix+20h or prefix+80h break the sequence.
- R11: A pulse appears on the clock edge that samples the strobed write and lasts one cycle. The mode priority is busy, identifier, suspended, bypass, read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_strobe | input | 1 | One bus write per high cycle |
| wr_addr | input | ADDR_W (18) | Write address, byte-granular in byte mode |
| wr_data | input | DATA_W (16) | Write data |
| byte_mode | input | 1 | 1 selects the byte-wide key addresses |
| ctl_busy | input | 1 | Program/erase controller is running |
| cmd_valid_o | output | 1 | One-cycle command pulse |
| cmd_o | output | 4 | Command code (1..10) |
| cmd_addr_o | output | ADDR_W (18) | Address of the completing write |
| cmd_data_o | output | DATA_W (16) | Data of the completing write |
| mode_o | output | 3 | 0 read, 1 identifier, 2 bypass, 3 busy, 4 suspended |

## Verification
The assertions assume that `ctl_busy` rises only after a program, erase or resume pulse and falls after suspend, reset or completion. They also assume that `wr_strobe` marks one write per cycle. The stimulus keeps to this by driving busy from a small controller model that reacts to the pulses the bench expects. The same controller holds busy for a randomly chosen number of writes. Random writes favour the key addresses and the command bytes, carry random high address and data bits, and switch the bus width from time to time, so that long sequences, breaks and gated writes all occur.

// File: rtl/nor_cmd_pkg.sv
`timescale 1ns/1ps
package nor_cmd_pkg;
    localparam int CMD_W   = 4;
    localparam int MODE_W  = 3;
    localparam int KEY_W   = 11;
    localparam int LSB_W   = KEY_W + 1;
    localparam int NUM_OPS = 11;

    localparam logic [KEY_W-1:0] W_CMD_KEY = 11'h555;
    localparam logic [KEY_W-1:0] W_UNL_KEY = 11'h2AA;
    localparam logic [LSB_W-1:0] B_CMD_KEY = 12'hAAA;
    localparam logic [LSB_W-1:0] B_UNL_KEY = 12'h555;

    localparam int OPI_AA = 0;
    localparam int OPI_55 = 1;
    localparam int OPI_F0 = 2;
    localparam int OPI_90 = 3;
    localparam int OPI_A0 = 4;
    localparam int OPI_20 = 5;
    localparam int OPI_80 = 6;
    localparam int OPI_10 = 7;
    localparam int OPI_30 = 8;
    localparam int OPI_B0 = 9;
    localparam int OPI_00 = 10;

    typedef enum logic [CMD_W-1:0] {
        CMD_NONE       = 4'd0,
        CMD_RESET      = 4'd1,
        CMD_IDENT      = 4'd2,
        CMD_PROG       = 4'd3,
        CMD_BYP_ENTER  = 4'd4,
        CMD_BYP_PROG   = 4'd5,
        CMD_BYP_RESET  = 4'd6,
        CMD_CHIP_ERASE = 4'd7,
        CMD_BLK_ERASE  = 4'd8,
        CMD_SUSPEND    = 4'd9,
        CMD_RESUME     = 4'd10
    } nor_cmd_e;

    typedef enum logic [MODE_W-1:0] {
        MD_READ    = 3'd0,
        MD_IDENT   = 3'd1,
        MD_BYPASS  = 3'd2,
        MD_BUSY    = 3'd3,
        MD_SUSPEND = 3'd4
    } nor_mode_e;

    typedef enum logic [1:0] {
        BASE_READ  = 2'd0,
        BASE_IDENT = 2'd1,
        BASE_BYP   = 2'd2
    } base_e;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_U1, SQ_U2, SQ_PROG, SQ_E3, SQ_E4, SQ_E5, SQ_BP, SQ_BR
    } seq_e;

    typedef struct packed {
        logic               at_cmd;
        logic               at_unl;
        logic [NUM_OPS-1:0] op;
    } wr_class_t;

    function automatic logic [7:0] op_code(int idx);
        case (idx)
            OPI_AA:  return 8'hAA;
            OPI_55:  return 8'h55;
            OPI_F0:  return 8'hF0;
            OPI_90:  return 8'h90;
            OPI_A0:  return 8'hA0;
            OPI_20:  return 8'h20;
            OPI_80:  return 8'h80;
            OPI_10:  return 8'h10;
            OPI_30:  return 8'h30;
            OPI_B0:  return 8'hB0;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic key_hit(logic [LSB_W-1:0] lsbs, logic bmode,
                                     logic [KEY_W-1:0] wkey, logic [LSB_W-1:0] bkey);
        if (bmode) return lsbs == bkey;
        return lsbs[KEY_W-1:0] == wkey;
    endfunction

    function automatic nor_mode_e pick_mode(logic busy, base_e base, logic susp);
        if (busy)              return MD_BUSY;
        if (base == BASE_IDENT) return MD_IDENT;
        if (susp)              return MD_SUSPEND;
        if (base == BASE_BYP)  return MD_BYPASS;
        return MD_READ;
    endfunction
endpackage

// File: rtl/nor_cmd_classify.sv
`timescale 1ns/1ps
module nor_cmd_classify
    import nor_cmd_pkg::*;
(
    input  logic [LSB_W-1:0] addr_lsbs,
    input  logic [7:0]       data_lo,
    input  logic             byte_mode,
    output wr_class_t        cls
);
    logic [NUM_OPS-1:0] op_hit;

    for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_op
        assign op_hit[gi] = (data_lo == op_code(gi));
    end

    assign cls = '{
        at_cmd: key_hit(addr_lsbs, byte_mode, W_CMD_KEY, B_CMD_KEY),
        at_unl: key_hit(addr_lsbs, byte_mode, W_UNL_KEY, B_UNL_KEY),
        op:     op_hit
    };
endmodule

// File: rtl/nor_cmd_seq.sv
`timescale 1ns/1ps
module nor_cmd_seq
    import nor_cmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_strobe,
    input  wr_class_t cls,
    input  logic      in_bypass,
    input  logic      suspended,
    input  logic      ctl_busy,
    input  logic      blk_op,
    output logic      ev_valid,
    output nor_cmd_e  ev_cmd,
    output logic      ev_break
);
    seq_e state_q, state_d;
    logic aa_cmd, u55;

    assign aa_cmd = cls.at_cmd && cls.op[OPI_AA];
    assign u55    = cls.at_unl && cls.op[OPI_55];

    always_comb begin
        state_d  = state_q;
        ev_valid = 1'b0;
        ev_cmd   = CMD_NONE;
        ev_break = 1'b0;
        if (wr_strobe) begin
            if (ctl_busy) begin
                state_d = SQ_IDLE;
                if (blk_op && cls.op[OPI_B0]) begin
                    ev_valid = 1'b1; ev_cmd = CMD_SUSPEND;
                end else if (blk_op && cls.op[OPI_F0]) begin
                    ev_valid = 1'b1; ev_cmd = CMD_RESET;
                end
            end else if (in_bypass) begin
                state_d = SQ_IDLE;
                case (state_q)
                    SQ_BP: begin
                        ev_valid = 1'b1; ev_cmd = CMD_BYP_PROG;
                    end
                    SQ_BR: begin
                        if (cls.op[OPI_00]) begin
                            ev_valid = 1'b1; ev_cmd = CMD_BYP_RESET;
                        end
                    end
                    default: begin
                        if (cls.op[OPI_A0])      state_d = SQ_BP;
                        else if (cls.op[OPI_90]) state_d = SQ_BR;
                    end
                endcase
            end else if (state_q == SQ_PROG) begin
                state_d  = SQ_IDLE;
                ev_valid = 1'b1; ev_cmd = CMD_PROG;
            end else if (cls.op[OPI_F0]) begin
                state_d  = SQ_IDLE;
                ev_valid = 1'b1; ev_cmd = CMD_RESET;
            end else begin
                state_d  = SQ_IDLE;
                ev_break = 1'b1;
                case (state_q)
                    SQ_IDLE: begin
                        if (aa_cmd) begin
                            state_d = SQ_U1; ev_break = 1'b0;
                        end else if (cls.op[OPI_30] && suspended) begin
                            ev_valid = 1'b1; ev_cmd = CMD_RESUME; ev_break = 1'b0;
                        end
                    end
                    SQ_U1: if (u55) begin state_d = SQ_U2; ev_break = 1'b0; end
                    SQ_U2: begin
                        if (cls.at_cmd) begin
                            if (cls.op[OPI_90]) begin
                                ev_valid = 1'b1; ev_cmd = CMD_IDENT; ev_break = 1'b0;
                            end else if (cls.op[OPI_A0]) begin
                                state_d = SQ_PROG; ev_break = 1'b0;
                            end else if (cls.op[OPI_20] && !suspended) begin
                                ev_valid = 1'b1; ev_cmd = CMD_BYP_ENTER; ev_break = 1'b0;
                            end else if (cls.op[OPI_80] && !suspended) begin
                                state_d = SQ_E3; ev_break = 1'b0;
                            end
                        end
                    end
                    SQ_E3: if (aa_cmd) begin state_d = SQ_E4; ev_break = 1'b0; end
                    SQ_E4: if (u55) begin state_d = SQ_E5; ev_break = 1'b0; end
                    SQ_E5: begin
                        if (cls.at_cmd && cls.op[OPI_10]) begin
                            ev_valid = 1'b1; ev_cmd = CMD_CHIP_ERASE; ev_break = 1'b0;
                        end else if (cls.op[OPI_30]) begin
                            ev_valid = 1'b1; ev_cmd = CMD_BLK_ERASE; ev_break = 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SQ_IDLE;
        else     state_q <= state_d;
    end

    // R8: a running program or chip erase lets nothing through
    p_busy_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_strobe && ctl_busy && !blk_op) |-> !ev_valid);

    // R7: bypass mode issues only its two shortened commands
    p_bypass_two_only_r7: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && in_bypass && !ctl_busy) |->
        (ev_cmd == CMD_BYP_PROG || ev_cmd == CMD_BYP_RESET));

    // R10: resume only while suspended
    p_resume_needs_susp_r10: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_cmd == CMD_RESUME) |-> suspended);
endmodule

// File: rtl/nor_cmd_mode.sv
`timescale 1ns/1ps
module nor_cmd_mode
    import nor_cmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ev_valid,
    input  nor_cmd_e  ev_cmd,
    input  logic      ev_break,
    input  logic      ctl_busy,
    output logic      in_bypass,
    output logic      suspended,
    output logic      blk_op,
    output nor_mode_e mode
);
    base_e base_q;
    logic  susp_q, blk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= BASE_READ;
            susp_q <= 1'b0;
            blk_q  <= 1'b0;
        end else if (ev_valid) begin
            case (ev_cmd)
                CMD_RESET:      base_q <= BASE_READ;
                CMD_IDENT:      base_q <= BASE_IDENT;
                CMD_PROG:       begin base_q <= BASE_READ; blk_q <= 1'b0; end
                CMD_BYP_ENTER:  base_q <= BASE_BYP;
                CMD_BYP_PROG:   blk_q <= 1'b0;
                CMD_BYP_RESET:  base_q <= BASE_READ;
                CMD_CHIP_ERASE: begin base_q <= BASE_READ; blk_q <= 1'b0; end
                CMD_BLK_ERASE:  begin base_q <= BASE_READ; blk_q <= 1'b1; end
                CMD_SUSPEND:    susp_q <= 1'b1;
                CMD_RESUME:     begin base_q <= BASE_READ; susp_q <= 1'b0; blk_q <= 1'b1; end
                default: ;
            endcase
        end else if (ev_break) begin
            base_q <= BASE_READ;
        end
    end

    assign in_bypass = (base_q == BASE_BYP);
    assign suspended = susp_q;
    assign blk_op    = blk_q;
    assign mode      = pick_mode(ctl_busy, base_q, susp_q);

    // R9: suspension is entered only through a suspend pulse
    p_susp_entry_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(susp_q) |-> $past(ev_valid && ev_cmd == CMD_SUSPEND));
endmodule

// File: rtl/nor_cmd_decoder.sv
`timescale 1ns/1ps
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_strobe,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              byte_mode,
    input  logic              ctl_busy,
    output logic              cmd_valid_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [DATA_W-1:0] cmd_data_o,
    output logic [MODE_W-1:0] mode_o
);
    wr_class_t cls;
    logic      ev_valid, ev_break, in_bypass, suspended, blk_op;
    nor_cmd_e  ev_cmd, cmd_q;
    nor_mode_e mode;

    nor_cmd_classify u_cls (
        .addr_lsbs (wr_addr[LSB_W-1:0]),
        .data_lo   (wr_data[7:0]),
        .byte_mode (byte_mode),
        .cls       (cls)
    );

    nor_cmd_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_strobe (wr_strobe),
        .cls       (cls),
        .in_bypass (in_bypass),
        .suspended (suspended),
        .ctl_busy  (ctl_busy),
        .blk_op    (blk_op),
        .ev_valid  (ev_valid),
        .ev_cmd    (ev_cmd),
        .ev_break  (ev_break)
    );

    nor_cmd_mode u_mode (
        .clk       (clk),
        .rst       (rst),
        .ev_valid  (ev_valid),
        .ev_cmd    (ev_cmd),
        .ev_break  (ev_break),
        .ctl_busy  (ctl_busy),
        .in_bypass (in_bypass),
        .suspended (suspended),
        .blk_op    (blk_op),
        .mode      (mode)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid_o <= 1'b0;
            cmd_q       <= CMD_NONE;
            cmd_addr_o  <= '0;
            cmd_data_o  <= '0;
        end else begin
            cmd_valid_o <= ev_valid;
            cmd_q       <= ev_cmd;
            if (ev_valid) begin
                cmd_addr_o <= wr_addr;
                cmd_data_o <= wr_data;
            end
        end
    end

    assign cmd_o  = cmd_q;
    assign mode_o = mode;

    // R11: every pulse follows a strobed write on the previous cycle
    p_pulse_after_write_r11: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |-> $past(wr_strobe));

    // R5: a reset outside a busy period lands in read or suspended mode
    p_reset_lands_read_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && cmd_o == CMD_RESET && !ctl_busy) |->
        (mode_o == MD_READ || mode_o == MD_SUSPEND));

    // R3: identifier mode holds while no write arrives
    p_ident_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MD_IDENT && !wr_strobe) |=> (mode_o == MD_IDENT || ctl_busy));
endmodule

// File: tb/nor_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module nor_cmd_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_strobe = 1'b0;
    logic [17:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        byte_mode = 1'b0;
    logic        ctl_busy = 1'b0;
    logic        cmd_valid;
    logic [3:0]  cmd;
    logic [17:0] cmd_addr;
    logic [15:0] cmd_data;
    logic [2:0]  mode;

    nor_cmd_decoder dut_i (
        .clk(clk), .rst(rst), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
        .wr_data(wr_data), .byte_mode(byte_mode), .ctl_busy(ctl_busy),
        .cmd_valid_o(cmd_valid), .cmd_o(cmd), .cmd_addr_o(cmd_addr),
        .cmd_data_o(cmd_data), .mode_o(mode)
    );

    always #2.5 clk = ~clk;

    int    total = 0, bad = 0;
    bit    finished = 1'b0;
    string cur_tag = "";
    int    m_st = 0, m_base = 0, busy_left = 0, busy_force = 0;
    bit    m_susp = 1'b0, m_blk = 1'b0;

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_mode();
        if (ctl_busy)    return 3;
        if (m_base == 1) return 1;
        if (m_susp)      return 4;
        if (m_base == 2) return 2;
        return 0;
    endfunction

    function automatic string tag_of(int c);
        case (c)
            0:       return "R6";
            1:       return "R5";
            5, 6:    return "R7";
            7, 8:    return "R4";
            9:       return "R9";
            10:      return "R10";
            default: return "R3";
        endcase
    endfunction

    function automatic logic [17:0] ca();
        return byte_mode ? 18'hAAA : 18'h555;
    endfunction

    function automatic logic [17:0] ua();
        return byte_mode ? 18'h555 : 18'h2AA;
    endfunction

    function automatic logic [7:0] op_of(int k);
        case (k)
            0: return 8'hAA;  1: return 8'h55;  2: return 8'hF0;  3: return 8'h90;
            4: return 8'hA0;  5: return 8'h20;  6: return 8'h80;  7: return 8'h10;
            8: return 8'h30;  9: return 8'hB0;  default: return 8'h00;
        endcase
    endfunction

    // expected command for one write, from the requirements
    task automatic model(input logic [17:0] a, input logic [15:0] d, output int c);
        bit at_c, at_u, brk;
        logic [7:0] b;
        at_c = byte_mode ? (a[11:0] == 12'hAAA) : (a[10:0] == 11'h555);
        at_u = byte_mode ? (a[11:0] == 12'h555) : (a[10:0] == 11'h2AA);
        b = d[7:0];
        brk = 1'b0;
        c = 0;
        if (ctl_busy) begin
            m_st = 0;
            if (m_blk && b == 8'hB0)      c = 9;
            else if (m_blk && b == 8'hF0) c = 1;
        end else if (m_base == 2) begin
            if (m_st == 7)                  c = 5;
            else if (m_st == 8 && b == 0)   c = 6;
            if (m_st == 0 && b == 8'hA0)      m_st = 7;
            else if (m_st == 0 && b == 8'h90) m_st = 8;
            else                              m_st = 0;
        end else if (m_st == 3) begin
            c = 3; m_st = 0;
        end else if (b == 8'hF0) begin
            c = 1; m_st = 0;
        end else begin
            case (m_st)
                0: if (b == 8'hAA && at_c) m_st = 1;
                   else if (b == 8'h30 && m_susp) c = 10;
                   else brk = 1;
                1: if (b == 8'h55 && at_u) m_st = 2; else brk = 1;
                2: if (!at_c) brk = 1;
                   else if (b == 8'h90) c = 2;
                   else if (b == 8'hA0) m_st = 3;
                   else if (b == 8'h20 && !m_susp) c = 4;
                   else if (b == 8'h80 && !m_susp) m_st = 4;
                   else brk = 1;
                4: if (b == 8'hAA && at_c) m_st = 5; else brk = 1;
                5: if (b == 8'h55 && at_u) m_st = 6; else brk = 1;
                6: if (b == 8'h10 && at_c) c = 7;
                   else if (b == 8'h30) c = 8;
                   else brk = 1;
                default: brk = 1;
            endcase
            if (brk || c != 0) m_st = 0;
        end
        if (brk) m_base = 0;
        case (c)
            1:  m_base = 0;
            2:  m_base = 1;
            3:  begin m_base = 0; m_blk = 0; end
            4:  m_base = 2;
            5:  m_blk = 0;
            6:  m_base = 0;
            7:  begin m_base = 0; m_blk = 0; end
            8:  begin m_base = 0; m_blk = 1; end
            9:  m_susp = 1;
            10: begin m_base = 0; m_susp = 0; m_blk = 1; end
            default: ;
        endcase
    endtask

    task automatic do_wr(input logic [17:0] a, input logic [15:0] d);
        int c, em;
        string t;
        @(negedge clk);
        chk("R11", "pulse gone", int'(cmd_valid), 0);
        wr_addr = a; wr_data = d; wr_strobe = 1'b1;
        model(a, d, c);
        em = exp_mode();
        @(negedge clk);
        wr_strobe = 1'b0;
        t = (cur_tag != "") ? cur_tag : tag_of(c);
        chk(t, "valid", int'(cmd_valid), int'(c != 0));
        chk(t, "cmd", int'(cmd), c);
        if (c != 0) begin
            chk(t, "addr", int'(cmd_addr), int'(a));
            chk(t, "data", int'(cmd_data), int'(d));
        end
        chk(ctl_busy ? "R8" : t, "mode", int'(mode), em);
        if (c == 3 || c == 5 || c == 7 || c == 8 || c == 10) begin
            ctl_busy = 1'b1;
            if (busy_force > 0)           busy_left = busy_force;
            else if (c == 8 || c == 10)   busy_left = 6 + int'($urandom % 6);
            else                          busy_left = 1 + int'($urandom % 4);
        end else if (c == 9 || (c == 1 && ctl_busy)) begin
            ctl_busy = 1'b0; busy_left = 0;
        end else if (ctl_busy) begin
            busy_left--;
            if (busy_left <= 0) ctl_busy = 1'b0;
        end
    endtask

    task automatic prefix();
        do_wr(ca(), 16'h00AA);
        do_wr(ua(), 16'h0055);
    endtask

    task automatic erase_head();
        prefix();
        do_wr(ca(), 16'h0080);
        prefix();
    endtask

    task automatic idle_mode(string tag, int exp);
        repeat (3) @(negedge clk);
        chk(tag, "idle mode", int'(mode), exp);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog run hung actual=1 expected=0");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0000C0DE));
        repeat (4) @(negedge clk);
        chk("R1", "reset mode", int'(mode), 0);
        chk("R1", "reset valid", int'(cmd_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "post-reset mode", int'(mode), 0);

        cur_tag = "R3";
        prefix(); do_wr(ca(), 16'h0090);
        idle_mode("R3", 1);
        cur_tag = "R6";
        do_wr(18'h01234, 16'h0077);
        do_wr(ca(), 16'h00AA); do_wr(ca(), 16'h0055);
        do_wr(ua(), 16'h0090);

        cur_tag = "R3"; busy_force = 3;
        prefix(); do_wr(ca(), 16'h00A0);
        do_wr(18'h2ABCD, 16'h12F0);
        cur_tag = "R8";
        do_wr(18'h00000, 16'h00F0); do_wr(18'h00000, 16'h00B0); do_wr(ca(), 16'h00AA);
        idle_mode("R8", 0);

        cur_tag = "R2";
        do_wr(18'h3F555, 16'hC3AA); do_wr(18'h3FAAA, 16'h5A55); do_wr(18'h1D555, 16'h7E90);
        do_wr(18'h00321, 16'hFFF0);
        byte_mode = 1'b1;
        do_wr(18'h00555, 16'h00AA);
        prefix(); do_wr(18'h2FAAA, 16'h0090);
        do_wr(18'h00000, 16'h00F0);
        byte_mode = 1'b0;

        cur_tag = "R4"; busy_force = 2;
        erase_head(); do_wr(ca(), 16'h0010);
        cur_tag = "R8";
        do_wr(18'h00000, 16'h00B0); do_wr(18'h00000, 16'h00F0);

        cur_tag = "R4"; busy_force = 20;
        erase_head(); do_wr(18'h30000, 16'h0030);
        cur_tag = "R9";
        do_wr(ca(), 16'h00AA); do_wr(18'h30000, 16'h00B0);
        idle_mode("R9", 4);

        cur_tag = "R10"; busy_force = 2;
        prefix(); do_wr(ca(), 16'h00A0); do_wr(18'h01000, 16'h0042);
        do_wr(18'h0, 16'h0011); do_wr(18'h0, 16'h0011);
        idle_mode("R10", 4);
        prefix(); do_wr(ca(), 16'h0020);
        prefix(); do_wr(ca(), 16'h0090);
        do_wr(18'h0, 16'h00F0);
        idle_mode("R10", 4);
        busy_force = 5;
        do_wr(18'h0, 16'h0030);
        cur_tag = "R9";
        do_wr(18'h0, 16'h00F0);
        idle_mode("R9", 0);

        cur_tag = "R7"; busy_force = 1;
        prefix(); do_wr(ca(), 16'h0020);
        do_wr(18'h0, 16'h00A0); do_wr(18'h0BEEF, 16'hBEEF);
        do_wr(18'h0, 16'h0000);
        do_wr(18'h0, 16'h0055);
        do_wr(18'h0, 16'h0090); do_wr(18'h0, 16'h0011);
        do_wr(18'h0, 16'h00F0);
        idle_mode("R7", 2);
        do_wr(18'h0, 16'h0090); do_wr(18'h0, 16'hFF00);

        cur_tag = "R5";
        prefix(); do_wr(18'h12345, 16'h00F0);

        cur_tag = ""; busy_force = 0;
        for (int n = 0; n < 4000; n++) begin
            int k, j;
            logic [17:0] a;
            logic [15:0] d;
            if (n % 500 == 499 && !ctl_busy) byte_mode = ~byte_mode;
            k = int'($urandom % 16);
            j = int'($urandom % 13);
            a = 18'($urandom);
            d = 16'($urandom);
            if (k < 6) begin
                if (byte_mode) a[11:0] = 12'hAAA; else a[10:0] = 11'h555;
            end else if (k < 11) begin
                if (byte_mode) a[11:0] = 12'h555; else a[10:0] = 11'h2AA;
            end
            if (j < 11) d[7:0] = op_of(j);
            do_wr(a, d);
        end

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule